// File: doc/BRIEF.md
# Downstream Root Port Status and Control Word

This block holds the 32-bit status-and-control word for a single downstream root port of a host controller. Software reaches it over a plain dword register bus: one write strobe with a full data word, and a read word that always shows the current contents. Port-side logic drives the live inputs: attach state, over-current, device speed, link-state updates, and pulses that mark the end of a reset or a configuration failure. The word combines four kinds of field. Some bits mirror that live state. Some are sticky change flags that software clears by writing one. Some are plain control fields. Link state only changes when its write strobe comes with the write.

A reset, plain or warm, starts from a register write. It stays pending as a request to the port side until that side returns a done pulse. A completed reset enables the port and captures the device speed. Any set change flag raises a single port-change request toward the interrupt logic. Link training, electrical signalling and reset timing are not built here. They appear only as the port-side input pulses.

Top module: `dnport_status_ctrl`

## Requirements
- R1: After reset the word reads 0x0000_0200: port power (bit 9) set, every other bit zero, `reset_req`, `warm_req` and `port_change` low.
- R2: Bit 0 shows `port_connect` one clock after it is sampled. Any change of `port_connect` sets the connect-change flag at bit 17. Losing the connection clears the speed field (bits 13:10) to 0.
- R3: The change flags at bits 23:17 clear only when a write has a one in the flag's position. A zero written there leaves the flag as it was. A new event in the same cycle as a clearing write leaves the flag set.
- R4: A write loads the link-state field (bits 8:5) only when bit 16 of the same write is one. Without it the field holds its value. Bit 16 always reads 0.
- R5: A `link_upd` pulse loads `link_val` into bits 8:5 and sets the link-change flag at bit 22. It overrides a software strobe write in the same cycle.
- R6: Writing one to bit 4 sets bit 4 and `reset_req`. Both stay set until a `rst_done` pulse. That pulse clears bit 4, sets the enable bit (bit 1) and the reset-change flag (bit 21), and latches `port_speed` into bits 13:10. Speed codes are 1 full, 2 low, 3 high, 4 super, and 0 undefined.
- R7: Writing one to bit 31 sets bit 31 and `warm_req` until a `warm_done` pulse. That pulse clears bit 31, sets bit 19 and enables the port (bit 1).
- R8: Writes have no effect on bits 0, 2, 3, 13:10, 24, 28, 29 and 30. Bit 30 shows `port_removable` one clock late. Writing one to bit 1 disables the port without setting bit 18. Writing zero to bit 1 has no effect.
- R9: Bit 3 shows `port_oc` one clock late, and any change of it sets bit 20. An over-current or a disconnect while the port is enabled clears bit 1 and sets the enable-change flag at bit 18.
- R10: Port power (bit 9), indicator (bits 15:14: 0 off, 1 amber, 2 green) and the wake enables (bit 25 connect, bit 26 disconnect, bit 27 over-current) are read/write.
- R11: `port_change` is high in exactly the cycles in which any of bits 23:17 reads one.
- R12: A `cfg_err` pulse sets the configuration-error flag at bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register word |
| port_connect | input | 1 | Device attached (level) |
| port_oc | input | 1 | Over-current present (level) |
| port_removable | input | 1 | Attached device is removable (level) |
| port_speed | input | 4 | Speed code reported by the port side |
| link_upd | input | 1 | Port-side link-state update pulse |
| link_val | input | 4 | Link state carried by the update |
| rst_done | input | 1 | Plain reset finished (pulse) |
| warm_done | input | 1 | Warm reset finished (pulse) |
| cfg_err | input | 1 | Link partner configuration failed (pulse) |
| reset_req | output | 1 | Plain reset requested of the port side |
| warm_req | output | 1 | Warm reset requested of the port side |
| port_change | output | 1 | Some change flag is set |

## Verification
The bench runs every link-state code through a write without the strobe and then with it. A design that ignored the strobe would move the field on the first of those writes. It also sweeps all 64 combinations of power, indicator and wake bits, and runs a reset for each defined speed code. This catches swapped field positions and a speed that is not latched at completion. The collision cases are targeted directly: a port-side link update against a strobe write, and a configuration error against a clearing write. A design with the wrong priority would show the software value or a cleared flag. Further checks cover writes to read-only bits, a zero written to the enable bit, and the enable bit being dropped by over-current or disconnect. Each of these shows up as a stray bit change, or as an enable-change flag set or missing when it should not be.

// File: rtl/dnport_pkg.sv
package dnport_pkg;
   localparam int WORD_W  = 32;
   localparam int B_CONN  = 0;
   localparam int B_EN    = 1;
   localparam int B_OC    = 3;
   localparam int B_RST   = 4;
   localparam int LS_LO   = 5;
   localparam int LS_W    = 4;
   localparam int B_PWR   = 9;
   localparam int SPD_LO  = 10;
   localparam int SPD_W   = 4;
   localparam int IND_LO  = 14;
   localparam int IND_W   = 2;
   localparam int B_LSTRB = 16;
   localparam int FLG_LO  = 17;
   localparam int FLG_N   = 7;
   localparam int WAKE_LO = 25;
   localparam int WAKE_W  = 3;
   localparam int B_RMV   = 30;
   localparam int B_WARM  = 31;

   // index of each change flag inside the flag vector (bit FLG_LO + index)
   typedef enum logic [2:0] {
      F_CONN = 3'd0,
      F_EN   = 3'd1,
      F_WARM = 3'd2,
      F_OC   = 3'd3,
      F_RST  = 3'd4,
      F_LINK = 3'd5,
      F_CFG  = 3'd6
   } flag_idx_e;

   typedef struct packed {
      logic              pwr;
      logic [IND_W-1:0]  ind;
      logic [WAKE_W-1:0] wake;
   } ctl_t;
endpackage

// File: rtl/dnport_chg_flags.sv
module dnport_chg_flags #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (rst)           q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;
         else if (clr_i[i]) q <= 1'b0;
      end
      assign flags_o[i] = q;
   end
endmodule

// File: rtl/dnport_link_state.sv
module dnport_link_state #(
   parameter int W       = 4,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sw_wr,
   input  logic         sw_strobe,
   input  logic [W-1:0] sw_val,
   input  logic         hw_upd,
   input  logic [W-1:0] hw_val,
   output logic [W-1:0] state_o
);
   localparam logic [W-1:0] RV = W'(RST_VAL);
   logic [W-1:0] st_q;
   always_ff @(posedge clk) begin
      if (rst)                     st_q <= RV;
      else if (hw_upd)             st_q <= hw_val;
      else if (sw_wr && sw_strobe) st_q <= sw_val;
   end
   assign state_o = st_q;
endmodule

// File: rtl/dnport_reset_seq.sv
module dnport_reset_seq (
   input  logic clk,
   input  logic rst,
   input  logic start_plain,
   input  logic start_warm,
   input  logic plain_done,
   input  logic warm_done,
   output logic plain_busy,
   output logic warm_busy,
   output logic plain_fin,
   output logic warm_fin
);
   logic pb_q, wb_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         pb_q <= 1'b0;
         wb_q <= 1'b0;
      end else begin
         if (pb_q && plain_done) pb_q <= 1'b0;
         else if (start_plain)   pb_q <= 1'b1;
         if (wb_q && warm_done)  wb_q <= 1'b0;
         else if (start_warm)    wb_q <= 1'b1;
      end
   end
   assign plain_busy = pb_q;
   assign warm_busy  = wb_q;
   // completion marks the 1-to-0 transition of the busy bit at this edge
   assign plain_fin  = pb_q && plain_done;
   assign warm_fin   = wb_q && warm_done;
endmodule

// File: rtl/dnport_status_ctrl.sv
module dnport_status_ctrl #(
   parameter int POWER_SWITCH  = 1,
   parameter int HAS_INDICATOR = 1,
   parameter int POWER_RESET   = 1,
   parameter int LINK_RESET    = 0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        port_connect,
   input  logic        port_oc,
   input  logic        port_removable,
   input  logic [3:0]  port_speed,
   input  logic        link_upd,
   input  logic [3:0]  link_val,
   input  logic        rst_done,
   input  logic        warm_done,
   input  logic        cfg_err,
   output logic        reset_req,
   output logic        warm_req,
   output logic        port_change
);
   import dnport_pkg::*;

   if (POWER_RESET != 0 && POWER_RESET != 1) begin : g_bad_pwr
      $error("POWER_RESET must be 0 or 1");
   end
   if (LINK_RESET < 0 || LINK_RESET >= (1 << LS_W)) begin : g_bad_link
      $error("LINK_RESET does not fit the link-state field");
   end
   if (POWER_SWITCH != 0 && POWER_SWITCH != 1) begin : g_bad_sw
      $error("POWER_SWITCH must be 0 or 1");
   end

   localparam logic PWR_RV = (POWER_RESET != 0);

   // ---------------- live status sampling ----------------
   logic conn_q, oc_q, rmv_q, en_q;
   logic [SPD_W-1:0] spd_q;
   logic conn_chg, oc_chg, lose, en_drop, sw_dis;
   logic plain_busy, warm_busy, plain_fin, warm_fin, any_fin;

   assign conn_chg = port_connect ^ conn_q;
   assign oc_chg   = port_oc ^ oc_q;
   assign lose     = !port_connect || port_oc;
   assign en_drop  = en_q && lose;
   assign sw_dis   = reg_wr && reg_wdata[B_EN];
   assign any_fin  = (plain_fin || warm_fin) && !lose;

   always_ff @(posedge clk) begin
      if (rst) begin
         conn_q <= 1'b0;
         oc_q   <= 1'b0;
         rmv_q  <= 1'b0;
         en_q   <= 1'b0;
         spd_q  <= '0;
      end else begin
         conn_q <= port_connect;
         oc_q   <= port_oc;
         rmv_q  <= port_removable;
         if (en_drop)      en_q <= 1'b0;
         else if (sw_dis)  en_q <= 1'b0;
         else if (any_fin) en_q <= 1'b1;
         if (!port_connect)                   spd_q <= '0;
         else if (plain_fin || warm_fin)      spd_q <= port_speed;
      end
   end

   // ---------------- reset sequencing ----------------
   dnport_reset_seq u_rseq (
      .clk         (clk),
      .rst         (rst),
      .start_plain (reg_wr && reg_wdata[B_RST]),
      .start_warm  (reg_wr && reg_wdata[B_WARM]),
      .plain_done  (rst_done),
      .warm_done   (warm_done),
      .plain_busy  (plain_busy),
      .warm_busy   (warm_busy),
      .plain_fin   (plain_fin),
      .warm_fin    (warm_fin)
   );

   // ---------------- link state ----------------
   logic [LS_W-1:0] ls;
   dnport_link_state #(.W(LS_W), .RST_VAL(LINK_RESET)) u_link (
      .clk       (clk),
      .rst       (rst),
      .sw_wr     (reg_wr),
      .sw_strobe (reg_wdata[B_LSTRB]),
      .sw_val    (reg_wdata[LS_LO +: LS_W]),
      .hw_upd    (link_upd),
      .hw_val    (link_val),
      .state_o   (ls)
   );

   // ---------------- change flags ----------------
   logic [FLG_N-1:0] fset, fclr, flags;
   always_comb begin
      fset         = '0;
      fset[F_CONN] = conn_chg;
      fset[F_EN]   = en_drop;
      fset[F_WARM] = warm_fin;
      fset[F_OC]   = oc_chg;
      fset[F_RST]  = plain_fin;
      fset[F_LINK] = link_upd;
      fset[F_CFG]  = cfg_err;
   end
   assign fclr = reg_wr ? reg_wdata[FLG_LO +: FLG_N] : '0;

   dnport_chg_flags #(.N(FLG_N)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .set_i   (fset),
      .clr_i   (fclr),
      .flags_o (flags)
   );

   // ---------------- software control fields ----------------
   ctl_t ctl;
   logic [WAKE_W-1:0] wake_q;
   always_ff @(posedge clk) begin
      if (rst)         wake_q <= '0;
      else if (reg_wr) wake_q <= reg_wdata[WAKE_LO +: WAKE_W];
   end
   assign ctl.wake = wake_q;

   if (POWER_SWITCH != 0) begin : g_pwr_rw
      logic pwr_q;
      always_ff @(posedge clk) begin
         if (rst)         pwr_q <= PWR_RV;
         else if (reg_wr) pwr_q <= reg_wdata[B_PWR];
      end
      assign ctl.pwr = pwr_q;
   end else begin : g_pwr_fixed
      assign ctl.pwr = 1'b1;
   end

   if (HAS_INDICATOR != 0) begin : g_ind_rw
      logic [IND_W-1:0] ind_q;
      always_ff @(posedge clk) begin
         if (rst)         ind_q <= '0;
         else if (reg_wr) ind_q <= reg_wdata[IND_LO +: IND_W];
      end
      assign ctl.ind = ind_q;
   end else begin : g_ind_none
      assign ctl.ind = '0;
   end

   // ---------------- read word ----------------
   always_comb begin
      reg_rdata                      = '0;
      reg_rdata[B_CONN]              = conn_q;
      reg_rdata[B_EN]                = en_q;
      reg_rdata[B_OC]                = oc_q;
      reg_rdata[B_RST]               = plain_busy;
      reg_rdata[LS_LO +: LS_W]       = ls;
      reg_rdata[B_PWR]               = ctl.pwr;
      reg_rdata[SPD_LO +: SPD_W]     = spd_q;
      reg_rdata[IND_LO +: IND_W]     = ctl.ind;
      reg_rdata[FLG_LO +: FLG_N]     = flags;
      reg_rdata[WAKE_LO +: WAKE_W]   = ctl.wake;
      reg_rdata[B_RMV]               = rmv_q;
      reg_rdata[B_WARM]              = warm_busy;
   end

   assign reset_req   = plain_busy;
   assign warm_req    = warm_busy;
   assign port_change = |flags;
endmodule

// File: rtl/dnport_status_ctrl_chk.sv
module dnport_status_ctrl_chk (
   input logic        clk,
   input logic        rst,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        port_connect,
   input logic        port_oc,
   input logic        rst_done,
   input logic        link_upd,
   input logic        port_change
);
   // R2: attach bit follows the input one clock late
   p_conn_follow_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> reg_rdata[0] == $past(port_connect));

   // R3: flags only fall after a clearing write
   p_w1c_conn_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(reg_rdata[17]) |-> $past(reg_wr && reg_wdata[17]));
   p_w1c_rstchg_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(reg_rdata[21]) |-> $past(reg_wr && reg_wdata[21]));

   // R4: link field holds without an update or a strobe write
   p_link_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(link_upd) && !$past(reg_wr && reg_wdata[16]))
      |-> reg_rdata[8:5] == $past(reg_rdata[8:5]));

   // R6: reset request persists until done
   p_reset_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (reg_rdata[4] && !rst_done) |=> reg_rdata[4]);
   p_reset_done_r6: assert property (@(posedge clk) disable iff (rst)
      (reg_rdata[4] && rst_done && port_connect && !port_oc && !(reg_wr && reg_wdata[1]))
      |=> (!reg_rdata[4] && reg_rdata[21] && reg_rdata[1]));

   // R11: change request tracks the flag bits
   p_change_hi_r11: assert property (@(posedge clk) disable iff (rst)
      (|reg_rdata[23:17]) |-> port_change);
   p_change_lo_r11: assert property (@(posedge clk) disable iff (rst)
      !(|reg_rdata[23:17]) |-> !port_change);
endmodule

bind dnport_status_ctrl dnport_status_ctrl_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .port_connect (port_connect),
   .port_oc      (port_oc),
   .rst_done     (rst_done),
   .link_upd     (link_upd),
   .port_change  (port_change)
);

// File: tb/dnport_status_ctrl_test.sv
module dnport_status_ctrl_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        port_connect = 1'b0, port_oc = 1'b0, port_removable = 1'b0;
   logic [3:0]  port_speed = '0;
   logic        link_upd = 1'b0;
   logic [3:0]  link_val = '0;
   logic        rst_done = 1'b0, warm_done = 1'b0, cfg_err = 1'b0;
   logic        reset_req, warm_req, port_change;

   int n_tests = 0;
   int n_fail  = 0;
   logic finished = 1'b0;
   logic [3:0] ls;

   always #10 clk = ~clk;   // 50 MHz

   dnport_status_ctrl uut (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst = 1'b0;
      // R1 reset state
      chk("R1 word", reg_rdata, 32'h0000_0200);
      chk("R1 outputs", {29'd0, reset_req, warm_req, port_change}, 32'd0);

      // R2 connect
      port_connect = 1'b1; step();
      chk("R2 connect word", reg_rdata, 32'h0002_0201);
      chk("R11 change high", {31'd0, port_change}, 32'd1);

      // R3 write zero keeps, write one clears
      wr(32'h0000_0200);
      chk("R3 zero write keeps flag", reg_rdata, 32'h0002_0201);
      wr(32'h0002_0200);
      chk("R3 w1c clears", reg_rdata, 32'h0000_0201);
      chk("R11 change low", {31'd0, port_change}, 32'd0);

      // R4 link-state sweep
      ls = 4'd0;
      for (int v = 0; v < 16; v++) begin
         wr(32'h200 | (32'(v) << 5));
         chk("R4 no strobe ignored", (reg_rdata >> 5) & 32'hF, 32'(ls));
         wr(32'h200 | (32'd1 << 16) | (32'(v) << 5));
         ls = 4'(v);
         chk("R4 strobe write", (reg_rdata >> 5) & 32'hF, 32'(ls));
         chk("R4 strobe reads zero", (reg_rdata >> 16) & 32'h1, 32'd0);
      end

      // R5 port update beats software strobe write
      link_val = 4'd9; link_upd = 1'b1;
      reg_wr = 1'b1; reg_wdata = 32'h200 | (32'd1 << 16) | (32'd3 << 5);
      step();
      link_upd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      ls = 4'd9;
      chk("R5 hw wins", (reg_rdata >> 5) & 32'hF, 32'd9);
      chk("R5 link flag", (reg_rdata >> 22) & 32'h1, 32'd1);
      wr(32'h200 | (32'd1 << 22));
      chk("R3 link flag cleared", (reg_rdata >> 22) & 32'h1, 32'd0);

      // R6 reset sequence for each speed
      for (int s = 1; s <= 4; s++) begin
         wr(32'h210);
         chk("R6 reset pending", {30'd0, reg_rdata[4], reset_req}, 32'd3);
         repeat (3) step();
         chk("R6 reset held", {31'd0, reg_rdata[4]}, 32'd1);
         port_speed = 4'(s); rst_done = 1'b1; step(); rst_done = 1'b0;
         chk("R6 reset done word", reg_rdata,
             32'h201 | (32'(ls) << 5) | 32'h2 | (32'(s) << 10) | (32'd1 << 21));
         chk("R6 request dropped", {31'd0, reset_req}, 32'd0);
         wr(32'h200 | (32'd1 << 21) | 32'h2);
         chk("R8 sw disable no flag", reg_rdata, 32'h201 | (32'(ls) << 5) | (32'(s) << 10));
      end

      // R8 read-only bits ignore writes
      wr(32'h200 | 32'h1 | 32'h4 | 32'h8 | (32'hF << 10) | (32'd1 << 24) | (32'd3 << 28) | (32'd1 << 30));
      chk("R8 ro bits", reg_rdata, 32'h201 | (32'(ls) << 5) | (32'd4 << 10));
      port_removable = 1'b1; step();
      chk("R8 removable shown", (reg_rdata >> 30) & 32'h1, 32'd1);
      wr(32'h200);
      chk("R8 removable not writable", (reg_rdata >> 30) & 32'h1, 32'd1);

      // R7 warm reset
      wr(32'h8000_0200);
      chk("R7 warm pending", {30'd0, reg_rdata[31], warm_req}, 32'd3);
      warm_done = 1'b1; step(); warm_done = 1'b0;
      chk("R7 warm done", {28'd0, reg_rdata[31], reg_rdata[19], reg_rdata[1], reg_rdata[21]}, 32'h6);
      wr(32'h200 | (32'd1 << 19));
      chk("R8 zero to enable no effect", {30'd0, reg_rdata[19], reg_rdata[1]}, 32'h1);

      // R9 over-current drops enable
      port_oc = 1'b1; step();
      chk("R9 oc word", reg_rdata & 32'h0014_000A, 32'h0014_0008);
      chk("R9 enable change", (reg_rdata >> 18) & 32'h1, 32'd1);
      port_oc = 1'b0; step();
      chk("R9 oc clear", (reg_rdata >> 3) & 32'h1, 32'd0);
      wr(32'h200 | (32'h7F << 17));
      chk("R3 all flags cleared", (reg_rdata >> 17) & 32'h7F, 32'd0);

      // R10 control field sweep
      for (int c = 0; c < 64; c++) begin
         logic [31:0] d;
         d = (32'(c & 1) << 9) | (32'((c >> 1) & 3) << 14) | (32'((c >> 3) & 7) << 25);
         wr(d);
         chk("R10 control fields", reg_rdata & 32'h0E00_C200, d);
      end
      wr(32'h200);

      // R12 config error, R3 set beats clear
      cfg_err = 1'b1; step(); cfg_err = 1'b0;
      chk("R12 cfg error", (reg_rdata >> 23) & 32'h1, 32'd1);
      cfg_err = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h200 | (32'd1 << 23);
      step();
      cfg_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      chk("R3 event beats clear", (reg_rdata >> 23) & 32'h1, 32'd1);
      wr(32'h200 | (32'd1 << 23));
      chk("R3 cfg cleared", (reg_rdata >> 23) & 32'h1, 32'd0);

      // R2 / R9 disconnect while enabled
      wr(32'h8000_0200);
      warm_done = 1'b1; step(); warm_done = 1'b0;
      wr(32'h200 | (32'd1 << 19));
      chk("R7 enabled again", reg_rdata & 32'h3C03, 32'h1003);
      port_connect = 1'b0; step();
      chk("R2 disconnect", reg_rdata & 32'h0006_3C03, 32'h0006_0000);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule